// File: doc/BRIEF.md
# Per-Core Banked Timer Register Window

This block sits between a processor-side register bus and a set of per-core countdown timers, one timer for each of 1 to 4 cores. The address space is cut into 32-byte windows. Window 0 is a shared alias: an access there reaches the timer that belongs to the core making the access, as named by the requester-ID input. Windows 1 to NUM_CORES each reach one core's timer directly, whoever makes the access. The two paths lead to the same timer, so they have the same effect.

The block decodes the window, steers the access to one timer select strobe, and forwards the write strobe, word index and write data in the same cycle. It captures the selected timer's read data into a response register one cycle later. Any access that does not land on a timer is dropped at the decode and reads back as zero. These are accesses through windows above the configured core count, accesses that are not a full aligned word, and alias accesses from an unknown requester. The last two also raise a one-cycle error flag. Each timer's interrupt goes out on its own line, in core order. NUM_CORES outside 1..4 stops elaboration.

Top module: `banked_timer_window`

## Requirements
- R1: The window index is `req_addr_i[ADDR_W-1:5]` and the word index is `req_addr_i[4:2]`. Window 1+i selects core i for every configured core i, and the word index goes out on `tmr_word_o`.
- R2: Window 0 selects the core whose number equals `req_cpu_i`. An alias access and a direct access to the same core and word have identical effects on timer state and read data.
- R3: An alias access with `req_cpu_i >= NUM_CORES` drives no select strobe and reads as zero. It sets `rsp_err_o` for exactly the one response cycle.
- R4: An access to a window above NUM_CORES drives no select strobe, reads as zero and does not set `rsp_err_o`.
- R5: Only accesses with `req_size_i == 2'b10` (a 32-bit word) and `req_addr_i[1:0] == 0` are accepted. Any other access drives no strobe, reads as zero and sets `rsp_err_o`.
- R6: At most one bit of `tmr_sel_o` is high. When it is high, `tmr_we_o` equals `req_write_i` and `tmr_wdata_o` equals `req_wdata_i`, in the same cycle as the request.
- R7: Every request produces `rsp_valid_o` on the following cycle, and there is no response without a request. The read data is the selected timer's word for a read, and zero for a write or a rejected access.
- R8: `irq_o[i]` follows `tmr_irq_i[i]` for each core i, with no added delay.
- R9: While `rst_ni` is low, `rsp_valid_o`, `rsp_err_o` and `rsp_rdata_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address within the block |
| req_size_i | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_cpu_i | input | 2 | Requester core ID |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rsp_rdata_o | output | 32 | Read data |
| rsp_err_o | output | 1 | Access rejected with error |
| tmr_sel_o | output | NUM_CORES | Per-core timer select strobe |
| tmr_we_o | output | 1 | Write strobe to selected timer |
| tmr_word_o | output | 3 | Word index inside the window |
| tmr_wdata_o | output | 32 | Write data to timers |
| tmr_rdata_i | input | 32*NUM_CORES | Read data from each timer, core 0 in the low bits |
| tmr_irq_i | input | NUM_CORES | Interrupt from each timer |
| irq_o | output | NUM_CORES | Interrupt lines, in core order |

## Verification
The bench builds the block with NUM_CORES = 3 and ADDR_W = 8, which gives eight windows. That leaves windows 4 to 7 unmapped, and it makes requester ID 3 a legal 2-bit value that names no core, so both rejection paths can be reached through the ports. Writes that should have no effect are followed by reads of all three timers through both window kinds, so any stray write shows up. The interrupt check uses a timer stub whose interrupt follows bit 0 of word 3.

// File: rtl/banked_timer_window_pkg.sv
package banked_timer_window_pkg;
  localparam int OFF_W   = 5;   // 32-byte window
  localparam int WORD_W  = 3;   // 8 words per window
  localparam int DATA_W  = 32;
  localparam int ID_W    = 2;
  localparam int MAX_CORES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  typedef struct packed {
    logic              valid;
    logic              err;
    logic [DATA_W-1:0] rdata;
  } rsp_t;
endpackage

// File: rtl/btw_win_decode.sv
module btw_win_decode
  import banked_timer_window_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int WIN_W = ADDR_W - OFF_W
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic [WIN_W-1:0]  win_o,
  output logic [WORD_W-1:0] word_o,
  output logic              ok_o,
  output logic              fmt_err_o
);
  logic fmt_good;

  assign win_o     = addr_i[ADDR_W-1:OFF_W];
  assign word_o    = addr_i[OFF_W-1:2];
  assign fmt_good  = (size_i == SZ_WORD) && (addr_i[1:0] == 2'b00);
  assign ok_o      = valid_i && fmt_good;
  assign fmt_err_o = valid_i && !fmt_good;
endmodule

// File: rtl/btw_core_steer.sv
module btw_core_steer
  import banked_timer_window_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int WIN_W     = 3
) (
  input  logic                 ok_i,
  input  logic [WIN_W-1:0]     win_i,
  input  logic [ID_W-1:0]      cpu_i,
  output logic [NUM_CORES-1:0] sel_o,
  output logic                 id_err_o
);
  logic alias_win;

  assign alias_win = (win_i == '0);
  assign id_err_o  = ok_i && alias_win && (32'(cpu_i) >= NUM_CORES);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic direct_hit, alias_hit;
    assign direct_hit = (32'(win_i) == i + 1);
    assign alias_hit  = alias_win && (32'(cpu_i) == i);
    assign sel_o[i]   = ok_i && (direct_hit || alias_hit);
  end
endmodule

// File: rtl/btw_rsp_reg.sv
module btw_rsp_reg
  import banked_timer_window_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic                        write_i,
  input  logic                        err_i,
  input  logic [NUM_CORES-1:0]        sel_i,
  input  logic [NUM_CORES*DATA_W-1:0] rdata_i,
  output rsp_t                        rsp_o
);
  logic [DATA_W-1:0] mux_data;
  rsp_t              rsp_q;

  // select is one-hot or zero, so an OR tree suffices
  always_comb begin
    mux_data = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (sel_i[i]) mux_data = mux_data | rdata_i[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q <= '0;
    end else begin
      rsp_q.valid <= valid_i;
      rsp_q.err   <= err_i;
      rsp_q.rdata <= (valid_i && !write_i) ? mux_data : '0;
    end
  end

  assign rsp_o = rsp_q;
endmodule

// File: rtl/banked_timer_window.sv
module banked_timer_window
  import banked_timer_window_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  input  logic                        req_write_i,
  input  logic [ADDR_W-1:0]           req_addr_i,
  input  logic [1:0]                  req_size_i,
  input  logic [ID_W-1:0]             req_cpu_i,
  input  logic [DATA_W-1:0]           req_wdata_i,
  output logic                        rsp_valid_o,
  output logic [DATA_W-1:0]           rsp_rdata_o,
  output logic                        rsp_err_o,
  output logic [NUM_CORES-1:0]        tmr_sel_o,
  output logic                        tmr_we_o,
  output logic [WORD_W-1:0]           tmr_word_o,
  output logic [DATA_W-1:0]           tmr_wdata_o,
  input  logic [NUM_CORES*DATA_W-1:0] tmr_rdata_i,
  input  logic [NUM_CORES-1:0]        tmr_irq_i,
  output logic [NUM_CORES-1:0]        irq_o
);
  localparam int WIN_W = ADDR_W - OFF_W;

  if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_cores
    $error("banked_timer_window: NUM_CORES must be 1..4");
  end
  if ((NUM_CORES + 1) > (1 << WIN_W)) begin : g_bad_addr
    $error("banked_timer_window: ADDR_W too small for all windows");
  end

  logic [WIN_W-1:0]     win;
  logic [WORD_W-1:0]    word;
  logic                 acc_ok, fmt_err, id_err;
  logic [NUM_CORES-1:0] sel;
  rsp_t                 rsp;

  btw_win_decode #(.ADDR_W(ADDR_W)) u_decode (
    .valid_i   (req_valid_i),
    .addr_i    (req_addr_i),
    .size_i    (req_size_i),
    .win_o     (win),
    .word_o    (word),
    .ok_o      (acc_ok),
    .fmt_err_o (fmt_err)
  );

  btw_core_steer #(.NUM_CORES(NUM_CORES), .WIN_W(WIN_W)) u_steer (
    .ok_i     (acc_ok),
    .win_i    (win),
    .cpu_i    (req_cpu_i),
    .sel_o    (sel),
    .id_err_o (id_err)
  );

  btw_rsp_reg #(.NUM_CORES(NUM_CORES)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .write_i (req_write_i),
    .err_i   (fmt_err || id_err),
    .sel_i   (sel),
    .rdata_i (tmr_rdata_i),
    .rsp_o   (rsp)
  );

  assign tmr_sel_o   = sel;
  assign tmr_we_o    = req_write_i && (|sel);
  assign tmr_word_o  = word;
  assign tmr_wdata_o = req_wdata_i;
  assign irq_o       = tmr_irq_i;

  assign rsp_valid_o = rsp.valid;
  assign rsp_err_o   = rsp.err;
  assign rsp_rdata_o = rsp.rdata;
endmodule

// File: rtl/btw_checker.sv
module btw_checker
  import banked_timer_window_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_write_i,
  input logic [ADDR_W-1:0]    req_addr_i,
  input logic [1:0]           req_size_i,
  input logic [ID_W-1:0]      req_cpu_i,
  input logic [DATA_W-1:0]    req_wdata_i,
  input logic                 rsp_valid_o,
  input logic [DATA_W-1:0]    rsp_rdata_o,
  input logic                 rsp_err_o,
  input logic [NUM_CORES-1:0] tmr_sel_o,
  input logic                 tmr_we_o,
  input logic [DATA_W-1:0]    tmr_wdata_o,
  input logic [NUM_CORES-1:0] tmr_irq_i,
  input logic [NUM_CORES-1:0] irq_o
);
  logic word_ok, alias_bad, win_high;
  assign word_ok   = (req_size_i == SZ_WORD) && (req_addr_i[1:0] == 2'b00);
  assign alias_bad = (req_addr_i[ADDR_W-1:OFF_W] == '0) && (32'(req_cpu_i) >= NUM_CORES);
  assign win_high  = 32'(req_addr_i[ADDR_W-1:OFF_W]) > NUM_CORES;

  // R6
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tmr_sel_o));
  // R6
  we_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tmr_sel_o) |-> (tmr_we_o == req_write_i) && (tmr_wdata_o == req_wdata_i));
  // R3
  bad_id_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && word_ok && alias_bad) |-> (tmr_sel_o == '0) ##1 (rsp_err_o && rsp_rdata_o == '0));
  // R4
  high_win_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && word_ok && win_high) |-> (tmr_sel_o == '0) ##1 (!rsp_err_o && rsp_rdata_o == '0));
  // R5
  bad_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !word_ok) |-> (tmr_sel_o == '0) ##1 rsp_err_o);
  // R7
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R7
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !rsp_err_o);
  // R8
  irq_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == tmr_irq_i);
  // R9
  always_comb begin
    if (!rst_ni) begin
      reset_rsp_chk: assert (!rsp_valid_o && !rsp_err_o && rsp_rdata_o == '0);
    end
  end
endmodule

bind banked_timer_window btw_checker #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_size_i  (req_size_i),
  .req_cpu_i   (req_cpu_i),
  .req_wdata_i (req_wdata_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_rdata_o (rsp_rdata_o),
  .rsp_err_o   (rsp_err_o),
  .tmr_sel_o   (tmr_sel_o),
  .tmr_we_o    (tmr_we_o),
  .tmr_wdata_o (tmr_wdata_o),
  .tmr_irq_i   (tmr_irq_i),
  .irq_o       (irq_o)
);

// File: tb/banked_timer_window_tb.sv
module banked_timer_window_tb;
  localparam int NC = 3;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic [1:0]      req_size = 2'b10;
  logic [1:0]      req_cpu = '0;
  logic [31:0]     req_wdata = '0;
  logic            rsp_valid, rsp_err;
  logic [31:0]     rsp_rdata;
  logic [NC-1:0]   tmr_sel, tmr_irq, irq;
  logic            tmr_we;
  logic [2:0]      tmr_word;
  logic [31:0]     tmr_wdata;
  logic [NC*32-1:0] tmr_rdata;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  banked_timer_window #(.NUM_CORES(NC), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_cpu_i(req_cpu), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .tmr_sel_o(tmr_sel), .tmr_we_o(tmr_we), .tmr_word_o(tmr_word),
    .tmr_wdata_o(tmr_wdata), .tmr_rdata_i(tmr_rdata), .tmr_irq_i(tmr_irq),
    .irq_o(irq)
  );

  // timer stub: 8 words per core, interrupt = bit 0 of word 3
  logic [31:0] stub_q [NC][8];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) for (int w = 0; w < 8; w++) stub_q[c][w] <= '0;
    end else begin
      for (int c = 0; c < NC; c++)
        if (tmr_sel[c] && tmr_we) stub_q[c][tmr_word] <= tmr_wdata;
    end
  end
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      tmr_rdata[c*32 +: 32] = stub_q[c][tmr_word];
      tmr_irq[c] = stub_q[c][3][0];
    end
  end

  // reference model
  logic [31:0] model [NC][8];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input string req, input bit we, input int win, input int word,
                        input logic [1:0] sz, input logic [1:0] lo, input int cpu,
                        input logic [31:0] wd);
    int tgt;
    bit exp_err;
    logic [31:0] exp_rd;
    logic [NC-1:0] exp_sel;
    req_valid = 1; req_write = we; req_size = sz; req_cpu = 2'(cpu); req_wdata = wd;
    req_addr = AW'((win << 5) | (word << 2) | lo);
    tgt = -1; exp_err = 0;
    if (sz != 2'b10 || lo != 0) exp_err = 1;
    else if (win == 0) begin
      if (cpu < NC) tgt = cpu; else exp_err = 1;
    end else if (win <= NC) tgt = win - 1;
    exp_sel = '0;
    if (tgt >= 0) exp_sel[tgt] = 1'b1;
    exp_rd = (!we && tgt >= 0) ? model[tgt][word] : 32'h0;
    #1;
    chk(req, "tmr_sel", tmr_sel, exp_sel);
    if (tgt >= 0) begin
      chk("R6", "tmr_we", tmr_we, we);
      chk("R1", "tmr_word", tmr_word, word);
    end
    @(posedge clk);
    if (we && tgt >= 0) model[tgt][word] = wd;
    @(negedge clk);
    chk("R7", "rsp_valid", rsp_valid, 1);
    chk(req, "rsp_rdata", rsp_rdata, exp_rd);
    chk(req, "rsp_err", rsp_err, exp_err);
    for (int c = 0; c < NC; c++) chk("R8", "irq", irq[c], model[c][3][0]);
  endtask

  task automatic idle();
    req_valid = 0;
    @(posedge clk); @(negedge clk);
    chk("R7", "idle rsp_valid", rsp_valid, 0);
    chk("R7", "idle rsp_err", rsp_err, 0);
  endtask

  task automatic sweep(input string req);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < 8; w++) access(req, 0, c + 1, w, 2'b10, 2'b00, 0, 0);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < 8; w++) access(req, 0, 0, w, 2'b10, 2'b00, c, 0);
  endtask

  initial begin
    for (int c = 0; c < NC; c++) for (int w = 0; w < 8; w++) model[c][w] = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "reset rsp_valid", rsp_valid, 0);
    chk("R9", "reset rsp_err", rsp_err, 0);
    chk("R9", "reset rsp_rdata", rsp_rdata, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 direct windows
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < 8; w++)
        access("R1", 1, c + 1, w, 2'b10, 2'b00, 3, 32'hA000_0000 | (c << 8) | w);
    sweep("R1");
    // R2 alias writes land on requester's timer, then cross reads
    for (int c = 0; c < NC; c++) access("R2", 1, 0, 5, 2'b10, 2'b00, c, 32'h5500_0000 + c);
    for (int c = 0; c < NC; c++) begin
      access("R2", 0, c + 1, 5, 2'b10, 2'b00, (c + 1) % NC, 0);
      access("R2", 0, 0, 5, 2'b10, 2'b00, c, 0);
    end
    // R8 interrupt via alias and direct
    access("R8", 1, 0, 3, 2'b10, 2'b00, 1, 32'h1);
    access("R8", 1, 3, 3, 2'b10, 2'b00, 0, 32'h1);
    access("R8", 1, 2, 3, 2'b10, 2'b00, 2, 32'h0);
    idle();
    // R3 unknown requester
    access("R3", 1, 0, 2, 2'b10, 2'b00, 3, 32'hDEAD_0003);
    access("R3", 0, 0, 2, 2'b10, 2'b00, 3, 0);
    idle();
    access("R3", 0, 0, 2, 2'b10, 2'b00, 0, 0);
    // R4 unmapped windows
    for (int w = NC + 1; w < 8; w++) begin
      access("R4", 1, w, 1, 2'b10, 2'b00, 0, 32'hBAD0_0000 | w);
      access("R4", 0, w, 1, 2'b10, 2'b00, 1, 0);
    end
    // R5 sub-word and misaligned
    access("R5", 1, 1, 4, 2'b00, 2'b00, 0, 32'hBEEF_0001);
    access("R5", 1, 2, 4, 2'b01, 2'b00, 0, 32'hBEEF_0002);
    access("R5", 1, 0, 4, 2'b10, 2'b01, 2, 32'hBEEF_0003);
    access("R5", 0, 3, 4, 2'b10, 2'b10, 0, 0);
    access("R5", 0, 1, 4, 2'b11, 2'b00, 0, 0);
    idle();
    // no stray writes from rejected accesses
    sweep("R3");
    sweep("R5");
    idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule